// File: doc/BRIEF.md
# Configurable Registered Address Buffer

This block registers the command and address lines of a memory module on the rising clock edge. Two static strap inputs pick how the lines are laid out. In the single-drive layout, 25 input positions each feed one registered output. In the twin-drive layout, 14 positions are registered, and each registered bit drives two identical copies: the A bank and the B bank. A second strap moves the clock-enable and on-die-termination sideband lines between two position maps in the twin-drive layout.

The ordinary data positions only update when at least one of two active-low select inputs is low. When both selects are high, the data outputs hold their values. The clock-enable, termination and select outputs never hold: they load on every edge. An active-low asynchronous reset clears every register and drives every output low at once. Release of the reset is synchronised into the clock domain.

All pins are plain registered signals. There is no valid/ready handshake and no back-pressure. A value is taken on every enabled edge, and the consumer sees it one edge later.

Top module: `cfgreg_top`

## Requirements
- R1: With `cfg_dual` low, `q_b` is all zero. Every `q_a` bit i carries the registered value of position i+1. Position 1 is clock-enable, position 4 is termination, position 7 is the select copy, and all other positions are data.
- R2: With `cfg_dual` high, `q_b[i]` equals `q_a[i]` for bits 0..13. Bits 14..24 of `q_a` stay low, and `din[24:14]` has no effect.
- R3: In the twin-drive layout, `cfg_alt_map` low puts clock-enable at position 1 and termination at position 4. `cfg_alt_map` high puts termination at position 11 and clock-enable at position 14. Position 7 is the select copy in every layout, and all other active positions are data.
- R4: While `rst_n` is low, `q_a` and `q_b` are zero. This holds with no clock edge needed.
- R5: After `rst_n` rises, registers capture first on rising edge number SYNC_STAGES+1 (the third edge by default).
- R6: On an edge with `cs_dev_n` and `cs_gate_n` both high, every data position keeps its previous value.
- R7: On an edge with either select low, every data position loads its `din` bit.
- R8: The clock-enable and termination positions load their `din` bits on every edge, whatever the selects are.
- R9: The select-copy position (position 7) registers `cs_dev_n` on every edge, independent of `cs_gate_n`. `din[6]` has no effect.
- R10: With `cs_gate_n` held low, the data positions load on every edge, whatever `cs_dev_n` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge capture clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dual | input | 1 | Static strap: 0 single-drive 25-bit, 1 twin-drive 14-bit |
| cfg_alt_map | input | 1 | Static strap: position map in twin-drive layout |
| cs_dev_n | input | 1 | Active-low device select, also registered to position 7 |
| cs_gate_n | input | 1 | Active-low select that combines with cs_dev_n for hold |
| din | input | 25 | Input positions 1..25 on bits 0..24 |
| q_a | output | 25 | Registered A-bank outputs, positions 1..25 |
| q_b | output | 14 | Registered B-bank copies, positions 1..14 |

## Verification
A register that is wrongly gated shows at the ports on the very next edge. A data bit that moves while both selects are high, or a sideband bit that freezes, is visible one edge after the stimulus. A wrong map decode puts a sideband value on a position where the bench expects held data. The bench changes sideband and data bits on the same hold edge so that either error is seen. A stuck synchroniser or a late release moves the first non-zero output away from the third edge, and the bench watches each edge in turn.

// File: rtl/cfgreg_pkg.sv
package cfgreg_pkg;
  localparam int NUM_POS  = 25;
  localparam int NUM_DUAL = 14;

  typedef enum logic [2:0] {
    K_DATA   = 3'd0,
    K_CKE    = 3'd1,
    K_ODT    = 3'd2,
    K_SEL    = 3'd3,
    K_UNUSED = 3'd4
  } kind_t;

  // Zero-based index of each fixed role.
  localparam int IDX_SEL     = 6;
  localparam int IDX_CKE_STD = 0;
  localparam int IDX_ODT_STD = 3;
  localparam int IDX_ODT_ALT = 10;
  localparam int IDX_CKE_ALT = 13;

  function automatic kind_t kind_of(input logic dual, input logic alt,
                                    input int idx, input int n_dual);
    kind_t k;
    k = K_DATA;
    if (idx == IDX_SEL)                 k = K_SEL;
    else if (dual && idx >= n_dual)     k = K_UNUSED;
    else if (dual && alt) begin
      if (idx == IDX_ODT_ALT)           k = K_ODT;
      else if (idx == IDX_CKE_ALT)      k = K_CKE;
    end else begin
      if (idx == IDX_CKE_STD)           k = K_CKE;
      else if (idx == IDX_ODT_STD)      k = K_ODT;
    end
    return k;
  endfunction
endpackage

// File: rtl/cfgreg_rst_sync.sv
module cfgreg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_int_n = chain[STAGES-1];
endmodule

// File: rtl/cfgreg_decode.sv
module cfgreg_decode
  import cfgreg_pkg::*;
#(
  parameter int N_POS  = NUM_POS,
  parameter int N_DUAL = NUM_DUAL
) (
  input  logic  dual,
  input  logic  alt,
  output kind_t kinds [N_POS]
);
  for (genvar p = 0; p < N_POS; p++) begin : g_kind
    assign kinds[p] = kind_of(dual, alt, p, N_DUAL);
  end
endmodule

// File: rtl/cfgreg_slice.sv
module cfgreg_slice
  import cfgreg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_int_n,
  input  kind_t kind,
  input  logic  d_bit,
  input  logic  cs_dev_n,
  input  logic  cs_gate_n,
  output logic  q
);
  logic hold;
  assign hold = cs_dev_n & cs_gate_n;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) q <= 1'b0;
    else begin
      unique case (kind)
        K_DATA:         q <= hold ? q : d_bit;
        K_CKE, K_ODT:   q <= d_bit;
        K_SEL:          q <= cs_dev_n;
        default:        q <= 1'b0;
      endcase
    end
  end

  // R6: data keeps its value on a hold edge
  a_r6_data_hold: assert property (@(posedge clk) disable iff (!rst_int_n)
    (kind == K_DATA && cs_dev_n && cs_gate_n) |=> (q == $past(q)));
  // R7 R10: data loads when a select is low
  a_r7_data_load: assert property (@(posedge clk) disable iff (!rst_int_n)
    (kind == K_DATA && !(cs_dev_n && cs_gate_n)) |=> (q == $past(d_bit)));
  // R8: sideband follows input every edge
  a_r8_side_load: assert property (@(posedge clk) disable iff (!rst_int_n)
    (kind == K_CKE || kind == K_ODT) |=> (q == $past(d_bit)));
  // R9: select copy follows cs_dev_n
  a_r9_sel_copy: assert property (@(posedge clk) disable iff (!rst_int_n)
    (kind == K_SEL) |=> (q == $past(cs_dev_n)));
endmodule

// File: rtl/cfgreg_top.sv
module cfgreg_top
  import cfgreg_pkg::*;
#(
  parameter int N_POS       = NUM_POS,
  parameter int N_DUAL      = NUM_DUAL,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_dual,
  input  logic              cfg_alt_map,
  input  logic              cs_dev_n,
  input  logic              cs_gate_n,
  input  logic [N_POS-1:0]  din,
  output logic [N_POS-1:0]  q_a,
  output logic [N_DUAL-1:0] q_b
);
  logic             rst_int_n;
  kind_t            kinds [N_POS];
  logic [N_POS-1:0] regs;

  cfgreg_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .rst_int_n(rst_int_n)
  );

  cfgreg_decode #(.N_POS(N_POS), .N_DUAL(N_DUAL)) u_dec (
    .dual(cfg_dual), .alt(cfg_alt_map), .kinds(kinds)
  );

  for (genvar p = 0; p < N_POS; p++) begin : g_slice
    cfgreg_slice u_slice (
      .clk(clk), .rst_int_n(rst_int_n), .kind(kinds[p]), .d_bit(din[p]),
      .cs_dev_n(cs_dev_n), .cs_gate_n(cs_gate_n), .q(regs[p])
    );
  end

  assign q_a = regs;
  assign q_b = cfg_dual ? regs[N_DUAL-1:0] : '0;

  // R4: outputs low while reset is held
  a_r4_reset_low: assert property (@(posedge clk)
    !rst_n |-> (q_a == '0 && q_b == '0));
  // R2: upper positions idle in twin-drive layout
  a_r2_upper_low: assert property (@(posedge clk) disable iff (!rst_int_n)
    cfg_dual |=> (q_a[N_POS-1:N_DUAL] == '0));
endmodule

// File: tb/sim_cfgreg_top.sv
module sim_cfgreg_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_dual = 1'b0, cfg_alt_map = 1'b0;
  logic        cs_dev_n = 1'b0, cs_gate_n = 1'b0;
  logic [24:0] din = '0;
  logic [24:0] q_a;
  logic [13:0] q_b;

  int n_run = 0, n_fail = 0;
  logic [24:0] model = '0;

  always #4 clk = ~clk;

  cfgreg_top u0 (
    .clk(clk), .rst_n(rst_n), .cfg_dual(cfg_dual), .cfg_alt_map(cfg_alt_map),
    .cs_dev_n(cs_dev_n), .cs_gate_n(cs_gate_n), .din(din), .q_a(q_a), .q_b(q_b)
  );

  // vector: {dual, alt, cs_dev_n, cs_gate_n, din[24:0]}
  localparam logic [28:0] VEC [12] = '{
    {4'b0000, 25'h1FFFFFF}, {4'b0011, 25'h0AAAAAA},
    {4'b0010, 25'h1555555}, {4'b0001, 25'h0F0F0F3},
    {4'b1000, 25'h1FFFFFF}, {4'b1011, 25'h0AAAAAA},
    {4'b1010, 25'h1555555}, {4'b1001, 25'h0F0F0F3},
    {4'b1100, 25'h1FFFFFF}, {4'b1111, 25'h0AAAAAA},
    {4'b1110, 25'h1555555}, {4'b1101, 25'h0F0F0F3}
  };

  // role per 1-based position: 0 data, 1 sideband, 2 select copy, 3 idle
  function automatic int role(input logic dual, input logic alt, input int pos);
    if (pos == 7) return 2;
    if (!dual) return (pos == 1 || pos == 4) ? 1 : 0;
    if (pos > 14) return 3;
    if (alt) return (pos == 11 || pos == 14) ? 1 : 0;
    return (pos == 1 || pos == 4) ? 1 : 0;
  endfunction

  task automatic step_model();
    logic [24:0] nx;
    nx = model;
    for (int pos = 1; pos <= 25; pos++) begin
      case (role(cfg_dual, cfg_alt_map, pos))
        0: if (!(cs_dev_n && cs_gate_n)) nx[pos-1] = din[pos-1];
        1: nx[pos-1] = din[pos-1];
        2: nx[pos-1] = cs_dev_n;
        default: nx[pos-1] = 1'b0;
      endcase
    end
    model = nx;
  endtask

  task automatic check(input logic ok, input string tag,
                       input logic [24:0] act, input logic [24:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_outs(input string tag);
    logic [13:0] exp_b;
    exp_b = cfg_dual ? model[13:0] : 14'h0;
    check(q_a == model, {tag, " q_a"}, q_a, model);
    check(q_b == exp_b, {tag, " q_b"}, {11'h0, q_b}, {11'h0, exp_b});
  endtask

  task automatic do_reset(input logic dual, input logic alt);
    @(negedge clk);
    rst_n = 1'b0; din = '0; cs_dev_n = 1'b0; cs_gate_n = 1'b0;
    cfg_dual = dual; cfg_alt_map = alt;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    model = '0;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1;
    // R4: reset state at time zero
    check(q_a == '0 && q_b == '0, "R4 initial reset", q_a, '0);
    for (int i = 0; i < 12; i++) begin
      if (i == 0 || VEC[i][28:27] != VEC[i-1][28:27])
        do_reset(VEC[i][28], VEC[i][27]);
      @(negedge clk);
      cs_dev_n = VEC[i][26]; cs_gate_n = VEC[i][25]; din = VEC[i][24:0];
      @(posedge clk);
      step_model();
      #1;
      check_outs($sformatf("vec%0d R1 R2 R3 R6 R7 R8 R9 R10", i));
    end

    // R10: gate low, dcs high, data loads in single-drive layout
    do_reset(1'b0, 1'b0);
    @(negedge clk); cs_dev_n = 1'b1; cs_gate_n = 1'b0; din = 25'h1234567;
    @(posedge clk); step_model(); #1;
    check_outs("R10 gate low load");

    // R4: asynchronous reset mid-cycle, twin-drive alt map
    do_reset(1'b1, 1'b1);
    @(negedge clk); cs_dev_n = 1'b0; cs_gate_n = 1'b1; din = 25'h1FFFFFF;
    @(posedge clk); step_model(); #2;
    check(q_a != '0, "R4 precondition", q_a, model);
    rst_n = 1'b0; #1;
    check(q_a == '0 && q_b == '0, "R4 async clear", q_a, '0);

    // R5: release timing; din held non-zero throughout
    @(negedge clk); rst_n = 1'b1; model = '0;
    @(posedge clk); #1;
    check(q_a == '0, "R5 edge1 no capture", q_a, '0);
    @(posedge clk); #1;
    check(q_a == '0, "R5 edge2 no capture", q_a, '0);
    @(posedge clk); step_model(); #1;
    // expected 0x3FBF: positions 1..14 high, position 7 copies cs_dev_n=0 (R9)
    check(q_a == 25'h0003FBF, "R5 R9 edge3 capture", q_a, 25'h0003FBF);
    check_outs("R5 R2 edge3 outputs");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule